// File: doc/BRIEF.md
# Priority-Nesting Interrupt Controller

This block collects interrupt requests from up to 64 sources and presents one CPU with a wake strobe and the index of the most urgent request it may take now. Every source has two ways in. A level line pends its source when the line rises. A one-cycle pulse pends its source directly.

For each source the controller keeps three things: a raw pending bit, an enable bit and an 8-bit priority. A raw pending bit survives while its source is masked, so enabling that source later delivers the request at once. A running-priority register holds the urgency of the handler now executing. Only requests strictly more urgent than that value are offered, and this is what allows handlers to nest. A global lock stops the wake strobe and the winner report, but requests still pend while it is set.

Software drives the controller through a one-command-per-cycle write port. The commands cover enable, disable, clearing, priority and running-priority writes, the lock, and re-checking a level line when its handler exits.

Top module: `prio_nest_intc`

## Requirements
- R1: After reset every priority is 255, the running priority is 256, no line is enabled or pending, the lock is clear, and both `win_valid_o` and `wake_o` are 0.
- R2: The winner is an enabled line with its status bit set and a priority value strictly below the running priority. The lowest priority value wins, and among equal values the lowest index wins. The winner is combinational from registered state.
- R3: A high `pulse_i[n]` at a clock edge sets the raw pending bit of line n whatever its mask is. It sets the status bit only if the line is enabled after that edge. If the lock was clear, `wake_o` is 1 for the one cycle after that edge, even when the line is masked.
- R4: A level line pends its source only on a rise of `level_i[n]` between two sampled edges. A low level, or a level held high, does not pend, and lowering the line does not clear a pend. A rise also wakes the CPU as in R3.
- R5: Command opcode 1 (enable, line in `cmd_line_i`) sets the mask bit. If the raw bit is set, it also sets the status bit and, when unlocked, pulses `wake_o` in the next cycle. Opcode 2 (disable) clears only the mask bit, so re-enabling brings the request back.
- R6: Opcode 8 with `cmd_data_i[0]`=1 sets the lock and with 0 clears it. While locked, `win_valid_o` is 0 and no wake is produced, but pends still update. Clearing the lock while any status bit is set pulses `wake_o` in the next cycle.
- R7: Opcode 3 clears the raw and status bits of one line. If a pend for that line comes in during the same cycle, the pend takes precedence.
- R8: Opcode 4 clears all raw and status bits. Opcode 5 clears all status bits, and clears raw bits only for lines that are enabled at that moment.
- R9: Opcode 9 re-pends the addressed line if its `level_i` is high in that cycle, and does nothing otherwise. It produces no wake.
- R10: Opcode 6 writes `cmd_data_i[7:0]` as the priority of the addressed line. Opcode 7 writes `cmd_data_i[8:0]` as the running priority. Any other opcode, or `cmd_valid_i`=0, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| level_i | input | 64 | Level request lines |
| pulse_i | input | 64 | One-cycle pend events |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 4 | Command opcode |
| cmd_line_i | input | 6 | Line addressed by the command |
| cmd_data_i | input | 9 | Priority, running priority or lock value |
| wake_o | output | 1 | One-cycle CPU wake strobe |
| win_valid_o | output | 1 | A line may preempt the running handler |
| win_idx_o | output | 6 | Index of that line |

## Verification
The winner is computed combinationally from registered state. A wrong pending, mask or priority bit therefore shows on `win_valid_o` or `win_idx_o` in the very cycle after the edge that corrupted it. A wrong wake decision shows as a missing or extra `wake_o` pulse one cycle after the command or event that caused it. The bench therefore compares both outputs on every cycle after every stimulus. It includes tie-breaks, the strict threshold at the running priority, and the extreme line index. Damage to pending state that the mask or the lock hides is brought out by later enabling the line or unlocking, and then watching the winner.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [3:0] {
    OP_NOP       = 4'd0,
    OP_ENABLE    = 4'd1,
    OP_DISABLE   = 4'd2,
    OP_CLEAR     = 4'd3,
    OP_CLEAR_ALL = 4'd4,
    OP_CLEAR_EN  = 4'd5,
    OP_SET_PRIO  = 4'd6,
    OP_SET_RUN   = 4'd7,
    OP_SET_LOCK  = 4'd8,
    OP_REEVAL    = 4'd9
  } op_e;
endpackage

// File: rtl/intc_pend_bank.sv
module intc_pend_bank import intc_pkg::*; #(
  parameter int N_LINES = 64,
  parameter int IDX_W   = $clog2(N_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] level_i,
  input  logic [N_LINES-1:0] pulse_i,
  input  logic               cmd_valid_i,
  input  op_e                op_i,
  input  logic [IDX_W-1:0]   line_i,
  output logic [N_LINES-1:0] raw_o,
  output logic [N_LINES-1:0] status_o,
  output logic [N_LINES-1:0] mask_o,
  output logic               new_pend_o,
  output logic               line_raw_o
);
  logic [N_LINES-1:0] level_q, raw_q, status_q, mask_q, evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= '0;
    else         level_q <= level_i;
  end

  // hardware events only; re-evaluation pends without waking
  assign evt        = pulse_i | (level_i & ~level_q);
  assign new_pend_o = |evt;
  assign line_raw_o = raw_q[line_i];

  for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line
    logic hit, pend, mask_d;
    assign hit    = cmd_valid_i && (line_i == IDX_W'(gi));
    assign pend   = evt[gi] || (hit && op_i == OP_REEVAL && level_i[gi]);
    assign mask_d = (hit && op_i == OP_ENABLE)  ? 1'b1 :
                    (hit && op_i == OP_DISABLE) ? 1'b0 : mask_q[gi];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        raw_q[gi]    <= 1'b0;
        status_q[gi] <= 1'b0;
        mask_q[gi]   <= 1'b0;
      end else begin
        mask_q[gi] <= mask_d;
        if (pend) begin
          raw_q[gi] <= 1'b1;
          if (mask_d) status_q[gi] <= 1'b1;
        end else if (cmd_valid_i && op_i == OP_CLEAR_ALL) begin
          raw_q[gi]    <= 1'b0;
          status_q[gi] <= 1'b0;
        end else if (cmd_valid_i && op_i == OP_CLEAR_EN) begin
          status_q[gi] <= 1'b0;
          if (mask_q[gi]) raw_q[gi] <= 1'b0;
        end else if (hit && op_i == OP_CLEAR) begin
          raw_q[gi]    <= 1'b0;
          status_q[gi] <= 1'b0;
        end else if (hit && op_i == OP_ENABLE && raw_q[gi]) begin
          status_q[gi] <= 1'b1;
        end
      end
    end

    assert_pulse_pends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_i[gi] |=> raw_q[gi]);
    assert_status_implies_raw_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_q[gi] |-> raw_q[gi]);
  end

  assign raw_o    = raw_q;
  assign status_o = status_q;
  assign mask_o   = mask_q;
endmodule

// File: rtl/intc_prio_regs.sv
module intc_prio_regs import intc_pkg::*; #(
  parameter int N_LINES = 64,
  parameter int PRIO_W  = 8,
  parameter int IDX_W   = $clog2(N_LINES)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           cmd_valid_i,
  input  op_e                            op_i,
  input  logic [IDX_W-1:0]               line_i,
  input  logic [PRIO_W-1:0]              data_i,
  output logic [N_LINES-1:0][PRIO_W-1:0] prio_o
);
  for (genvar gi = 0; gi < N_LINES; gi++) begin : g_prio
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        prio_o[gi] <= '1;
      else if (cmd_valid_i && op_i == OP_SET_PRIO && line_i == IDX_W'(gi))
        prio_o[gi] <= data_i;
    end
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int N_LINES = 64,
  parameter int PRIO_W  = 8,
  parameter int IDX_W   = $clog2(N_LINES)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_LINES-1:0]             status_i,
  input  logic [N_LINES-1:0]             mask_i,
  input  logic [N_LINES-1:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W:0]                run_i,
  output logic                           found_o,
  output logic [IDX_W-1:0]               idx_o
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '1;
    // ascending scan with strict compare keeps the lowest index on ties
    for (int i = 0; i < N_LINES; i++) begin
      if (status_i[i] && mask_i[i] && ({1'b0, prio_i[i]} < run_i) &&
          (!found_o || prio_i[i] < best)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        best    = prio_i[i];
      end
    end
  end

  assert_winner_pending_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> (status_i[idx_o] && mask_i[idx_o]));
endmodule

// File: rtl/prio_nest_intc.sv
module prio_nest_intc import intc_pkg::*; #(
  parameter int N_LINES = 64,
  parameter int PRIO_W  = 8,
  localparam int IDX_W  = $clog2(N_LINES),
  localparam int RUN_W  = PRIO_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] level_i,
  input  logic [N_LINES-1:0] pulse_i,
  input  logic               cmd_valid_i,
  input  logic [3:0]         cmd_op_i,
  input  logic [IDX_W-1:0]   cmd_line_i,
  input  logic [RUN_W-1:0]   cmd_data_i,
  output logic               wake_o,
  output logic               win_valid_o,
  output logic [IDX_W-1:0]   win_idx_o
);
  op_e                            op;
  logic [N_LINES-1:0]             raw, status, mask;
  logic [N_LINES-1:0][PRIO_W-1:0] prio;
  logic                           new_pend, line_raw, found, lock_q, unlock_cmd, wake_d;
  logic [RUN_W-1:0]               run_q;

  assign op = op_e'(cmd_op_i);

  intc_pend_bank #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_bank (
    .clk_i, .rst_ni, .level_i, .pulse_i, .cmd_valid_i,
    .op_i(op), .line_i(cmd_line_i),
    .raw_o(raw), .status_o(status), .mask_o(mask),
    .new_pend_o(new_pend), .line_raw_o(line_raw)
  );

  intc_prio_regs #(.N_LINES(N_LINES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_prio (
    .clk_i, .rst_ni, .cmd_valid_i, .op_i(op), .line_i(cmd_line_i),
    .data_i(cmd_data_i[PRIO_W-1:0]), .prio_o(prio)
  );

  intc_arbiter #(.N_LINES(N_LINES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
    .clk_i, .rst_ni, .status_i(status), .mask_i(mask), .prio_i(prio),
    .run_i(run_q), .found_o(found), .idx_o(win_idx_o)
  );

  assign unlock_cmd = cmd_valid_i && op == OP_SET_LOCK && !cmd_data_i[0];
  assign wake_d = (!lock_q && (new_pend || (cmd_valid_i && op == OP_ENABLE && line_raw))) ||
                  (lock_q && unlock_cmd && ((|status) || new_pend));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      run_q  <= RUN_W'(1) << PRIO_W;
      wake_o <= 1'b0;
    end else begin
      wake_o <= wake_d;
      if (cmd_valid_i && op == OP_SET_LOCK) lock_q <= cmd_data_i[0];
      if (cmd_valid_i && op == OP_SET_RUN)  run_q  <= cmd_data_i;
    end
  end

  assign win_valid_o = found && !lock_q;

  assert_lock_holds_wake_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !unlock_cmd) |=> !wake_o);
  assert_winner_beats_run_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> ({1'b0, prio[win_idx_o]} < run_q));
  assert_unused_raw_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_valid_o && !lock_q) |-> raw[win_idx_o]);
endmodule

// File: tb/sim_prio_nest_intc.sv
module sim_prio_nest_intc;
  localparam int N = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] level = '0, pulse = '0;
  logic         cmd_valid = 1'b0;
  logic [3:0]   cmd_op = '0;
  logic [5:0]   cmd_line = '0;
  logic [8:0]   cmd_data = '0;
  logic         wake, win_valid;
  logic [5:0]   win_idx;

  int cyc = 0, n_chk = 0, n_bad = 0;

  typedef struct {
    int          due;
    logic        wake;
    logic        valid;
    logic [5:0]  idx;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  prio_nest_intc u0 (
    .clk_i(clk), .rst_ni(rst_n), .level_i(level), .pulse_i(pulse),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_line_i(cmd_line),
    .cmd_data_i(cmd_data), .wake_o(wake), .win_valid_o(win_valid), .win_idx_o(win_idx)
  );

  task automatic cmp(input exp_t e);
    n_chk++;
    if (wake !== e.wake || win_valid !== e.valid || (e.valid && win_idx !== e.idx)) begin
      n_bad++;
      $display("FAIL %s: wake/valid/idx = %0b/%0b/%0d expected %0b/%0b/%0d",
               e.tag, wake, win_valid, win_idx, e.wake, e.valid, e.idx);
    end
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    while (sb.size() > 0 && sb[0].due == cyc) cmp(sb.pop_front());
  end

  // driver: one cycle per call, expectation holds after the edge
  task automatic step(input logic [3:0] op, input int line, input int data,
                      input int pline, input logic ew, input logic ev, input int ei,
                      input string tag);
    exp_t e;
    @(negedge clk);
    cmd_valid = (op != 0);
    cmd_op    = op;
    cmd_line  = 6'(line);
    cmd_data  = 9'(data);
    pulse     = '0;
    if (pline >= 0) pulse[pline] = 1'b1;
    e.due = cyc + 1; e.wake = ew; e.valid = ev; e.idx = 6'(ei); e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic lvl(input int line, input logic v, input logic ew, input logic ev,
                     input int ei, input string tag);
    exp_t e;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0; pulse = '0;
    level[line] = v;
    e.due = cyc + 1; e.wake = ew; e.valid = ev; e.idx = 6'(ei); e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    #5000000;
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    r.due = 0; r.wake = 0; r.valid = 0; r.idx = 0; r.tag = "R1 reset";
    cmp(r);
    rst_n = 1'b1;
    // R3 masked pulse: wakes, no winner
    step(0, 0, 0, 5, 1, 0, 0, "R3 masked pulse wakes");
    step(0, 0, 0, -1, 0, 0, 0, "R3 wake is one cycle");
    // R5 enable delivers stored pend; prio 255 < run 256 (R1)
    step(1, 5, 0, -1, 1, 1, 5, "R5 enable pending wakes R1");
    step(0, 0, 0, -1, 0, 1, 5, "R5 hold");
    step(2, 5, 0, -1, 0, 0, 0, "R5 disable hides");
    step(1, 5, 0, -1, 1, 1, 5, "R5 re-enable restores");
    // R2 ordering
    step(6, 9, 10, -1, 0, 1, 5, "R10 prio write");
    step(1, 9, 0, -1, 0, 1, 5, "R5 enable no pend no wake");
    step(0, 0, 0, 9, 1, 1, 9, "R2 lower value wins");
    step(6, 5, 10, -1, 0, 1, 5, "R2 tie lowest index");
    step(7, 0, 10, -1, 0, 0, 0, "R10 run equal blocks");
    step(7, 0, 11, -1, 0, 1, 5, "R10 run above admits");
    step(7, 0, 256, -1, 0, 1, 5, "R10 run idle");
    // R7
    step(3, 5, 0, -1, 0, 1, 9, "R7 clear one");
    step(3, 9, 0, 9, 1, 1, 9, "R7 pend beats clear");
    step(4, 0, 0, -1, 0, 0, 0, "R8 clear all");
    // R6
    step(8, 0, 1, -1, 0, 0, 0, "R6 lock");
    step(0, 0, 0, 5, 0, 0, 0, "R6 locked pend no wake");
    step(8, 0, 0, -1, 1, 1, 5, "R6 unlock wakes");
    // R8 clear-all-enabled
    step(0, 0, 0, 20, 1, 1, 5, "R3 masked pend keeps winner");
    step(5, 0, 0, -1, 0, 0, 0, "R8 clear enabled");
    step(1, 20, 0, -1, 1, 1, 20, "R8 masked raw survives");
    step(1, 5, 0, -1, 0, 1, 20, "R8 enabled raw removed");
    step(4, 0, 0, -1, 0, 0, 0, "R8 clear all again");
    // R4 / R9 level lines
    step(1, 30, 0, -1, 0, 0, 0, "R5 enable 30");
    lvl(30, 1, 1, 1, 30, "R4 rise pends");
    lvl(30, 1, 0, 1, 30, "R4 held no new wake");
    lvl(30, 0, 0, 1, 30, "R4 fall keeps pend");
    step(3, 30, 0, -1, 0, 0, 0, "R7 clear level line");
    lvl(30, 1, 1, 1, 30, "R4 second rise");
    step(3, 30, 0, -1, 0, 0, 0, "R4 held high no repend");
    step(9, 30, 0, -1, 0, 1, 30, "R9 reeval repends");
    lvl(30, 0, 0, 1, 30, "R4 lower");
    step(3, 30, 0, -1, 0, 0, 0, "R7 clear");
    step(9, 30, 0, -1, 0, 0, 0, "R9 reeval low no pend");
    // boundary line 63, nesting threshold
    step(1, 63, 0, -1, 0, 0, 0, "R5 enable 63");
    step(0, 0, 0, 63, 1, 1, 63, "R2 top index");
    step(7, 0, 255, -1, 0, 0, 0, "R10 run 255 blocks prio 255");
    step(6, 63, 0, -1, 0, 1, 63, "R10 prio 0 preempts");
    step(7, 0, 0, -1, 0, 0, 0, "R10 run 0 blocks all");
    step(7, 0, 1, -1, 0, 1, 63, "R10 run 1 admits prio 0");
    step(11, 63, 0, -1, 0, 1, 63, "R10 unused opcode ignored");
    step(0, 0, 0, -1, 0, 1, 63, "R10 idle");
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: %0d left expected 0", sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule